// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Front End

This block is the control front end of a 256K x 4 dynamic memory whose interface is driven by asynchronous-style active-low strobes: a row strobe, a column strobe, a write strobe and an output-enable strobe. It shares one 9-bit address bus between the row and the column and carries 4-bit data words. A fast system clock samples every strobe. Edges are found by comparing each sample with the one before. The order in which the strobes change selects the kind of cycle: read, early write, write-after-read (read-modify-write, which also covers output-enable-controlled write), fast page, refresh of an addressed row, or refresh from an internal counter when the column strobe leads the row strobe (this includes hidden refresh).

The storage behind the front end is a small array. It is indexed by the low `ROW_KEEP` bits of the latched row and the low `COL_KEEP` bits of the latched column. With both set to 9 the array would hold the full 512 x 512 words; the defaults keep it small. Refresh does not touch the data. It shows up as a one-cycle pulse together with the 9-bit row that was refreshed. The data port is split into an input word, an output word and a drive flag, so that a pad ring can build the bidirectional pins from them.

Top module: `dram_front`

## Requirements
- R1: The row address is latched when a falling row strobe is sampled with the column strobe high. The column address is latched when a falling column strobe is sampled inside that row. The stored word is selected by row bits [ROW_KEEP-1:0] and column bits [COL_KEEP-1:0], so addresses that differ only above those bits alias to the same word.
- R2: `dqDrive` is 1 only while a read word is held and both the column strobe and the output-enable strobe are low. It drops as soon as either strobe goes high. `dqOut` carries the word read at the latest column fall.
- R3: When the write strobe is already low at a sampled column fall, `dqIn` is written at that edge. No word is driven until the column strobe rises, whatever the output-enable strobe does.
- R4: While the row strobe stays low, each further column-strobe low pulse latches a new column in the same row, and each pulse may be a read or a write.
- R5: A write strobe that falls while the column strobe is low after a read writes the `dqIn` present at that sample into the same word. The word read earlier stays on `dqOut`.
- R6: A row-strobe low pulse during which the column strobe stays high produces one `refreshPulse` in the cycle after the rising edge is sampled, with `refreshRow` equal to the full 9-bit latched row. Write and output-enable strobes have no effect on storage in such a cycle. No other normal cycle produces a pulse.
- R7: When the column strobe is already low at a sampled row fall, the cycle is a counter refresh. `refreshPulse` is raised the next cycle with `refreshRow` equal to the internal counter, and the counter then increments. Address, write strobe and data are ignored, and storage is unchanged.
- R8: The refresh counter is 9 bits wide, starts at 0 after reset, and wraps from 511 to 0.
- R9: Hidden refresh: after a read, the column strobe is held low while the row strobe goes high and then low again. `dqDrive` stays 1 with the same `dqOut` throughout, and the refresh takes its row from the counter.
- R10: During and right after reset, `dqDrive` and `refreshPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than the strobes |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output-enable strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DATA_W | Write data from the pins |
| dqOut | output | DATA_W | Read data toward the pins |
| dqDrive | output | 1 | 1 when the pins should be driven with dqOut |
| refreshPulse | output | 1 | One-cycle marker of a completed refresh |
| refreshRow | output | ADDR_W | Row refreshed by the latest refresh |

## Verification
The hardest situation to reach is hidden refresh. It needs a read with both low strobes still held, then a row-strobe rise that must not count as an addressed refresh, then a second row fall that must be taken as a counter refresh while the output keeps driving. The stimulus gets there by opening a row, reading with output enable low, and toggling only the row strobe. The drive flag and the data are checked after each toggle. Counter wrap is reached by a long run of counter refreshes, each pulse row compared against a scoreboard queue until 511 rolls over to 0.

// File: rtl/dram_front_pkg.sv
package dram_front_pkg;

  // strobes passed from control to datapath, one cycle each
  typedef struct packed {
    logic rowLoad;    // capture addr as row
    logic colLoad;    // capture addr as column
    logic wrNow;      // write dqIn into selected word
    logic rdNow;      // load selected word into read register
    logic rdClr;      // drop the held read word
    logic refFire;    // a refresh completes this edge
    logic refUseCnt;  // refresh row comes from the counter
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_CBR  = 2'd2
  } phase_e;

endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_front_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  output ctlStrobe_t strb
);

  logic   rasQ, casQ, weQ;
  phase_e phase, phaseNx;
  logic   rasOnly, rasOnlyNx;
  logic   colRead, colReadNx;

  logic rasFall, rasRise, casFall, casRise, weFall;

  assign rasFall = rasQ & ~rasN;
  assign rasRise = ~rasQ & rasN;
  assign casFall = casQ & ~casN;
  assign casRise = ~casQ & casN;
  assign weFall  = weQ & ~weN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasQ    <= 1'b1;
      casQ    <= 1'b1;
      weQ     <= 1'b1;
      phase   <= PH_IDLE;
      rasOnly <= 1'b0;
      colRead <= 1'b0;
    end else begin
      rasQ    <= rasN;
      casQ    <= casN;
      weQ     <= weN;
      phase   <= phaseNx;
      rasOnly <= rasOnlyNx;
      colRead <= colReadNx;
    end
  end

  always_comb begin
    strb      = '0;
    phaseNx   = phase;
    rasOnlyNx = rasOnly;
    colReadNx = colRead;

    if (casRise) begin
      strb.rdClr = 1'b1;
      colReadNx  = 1'b0;
    end

    unique case (phase)
      PH_IDLE: begin
        if (rasFall) begin
          if (!casN) begin
            // column strobe leads: counter refresh
            strb.refFire   = 1'b1;
            strb.refUseCnt = 1'b1;
            phaseNx        = PH_CBR;
          end else begin
            strb.rowLoad = 1'b1;
            rasOnlyNx    = 1'b1;
            phaseNx      = PH_ROW;
          end
        end
      end
      PH_ROW: begin
        if (rasRise) begin
          if (rasOnly) strb.refFire = 1'b1;
          rasOnlyNx = 1'b0;
          colReadNx = 1'b0;
          phaseNx   = PH_IDLE;
        end else if (casFall) begin
          strb.colLoad = 1'b1;
          rasOnlyNx    = 1'b0;
          if (!weN) begin
            strb.wrNow = 1'b1;      // early write
          end else begin
            strb.rdNow = 1'b1;
            colReadNx  = 1'b1;
          end
        end else if (weFall && colRead && !casN) begin
          strb.wrNow = 1'b1;        // write after read
        end
      end
      PH_CBR: begin
        if (rasRise) phaseNx = PH_IDLE;
      end
      default: phaseNx = PH_IDLE;
    endcase
  end

endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_front_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 4,
  parameter int ROW_KEEP = 3,
  parameter int COL_KEEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdWord,
  output logic              rdValid,
  output logic              refPulse,
  output logic [ADDR_W-1:0] refRow
);

  localparam int IDX_W = ROW_KEEP + COL_KEEP;
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0]   rowReg;
  logic [COL_KEEP-1:0] colReg;
  logic [COL_KEEP-1:0] colSel;
  logic [IDX_W-1:0]    wordIdx;
  logic [ADDR_W-1:0]   refCnt;
  logic [DATA_W-1:0]   store [DEPTH];

  assign colSel  = strb.colLoad ? addr[COL_KEEP-1:0] : colReg;
  assign wordIdx = {rowReg[ROW_KEEP-1:0], colSel};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (strb.rowLoad) rowReg <= addr;
      if (strb.colLoad) colReg <= addr[COL_KEEP-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrNow) store[wordIdx] <= dqIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWord  <= '0;
      rdValid <= 1'b0;
    end else if (strb.rdNow) begin
      rdWord  <= store[wordIdx];
      rdValid <= 1'b1;
    end else if (strb.rdClr) begin
      rdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt   <= '0;
      refRow   <= '0;
      refPulse <= 1'b0;
    end else begin
      refPulse <= strb.refFire;
      if (strb.refFire) begin
        refRow <= strb.refUseCnt ? refCnt : rowReg;
        if (strb.refUseCnt) refCnt <= refCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_front.sv
module dram_front
  import dram_front_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 4,
  parameter int ROW_KEEP = 3,
  parameter int COL_KEEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqDrive,
  output logic              refreshPulse,
  output logic [ADDR_W-1:0] refreshRow
);

  ctlStrobe_t strb;
  logic       rdValid;

  dram_ctrl ctrlInst (
    .clk  (clk),
    .rstN (rstN),
    .rasN (rasN),
    .casN (casN),
    .weN  (weN),
    .strb (strb)
  );

  dram_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ROW_KEEP (ROW_KEEP),
    .COL_KEEP (COL_KEEP)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .dqIn     (dqIn),
    .rdWord   (dqOut),
    .rdValid  (rdValid),
    .refPulse (refreshPulse),
    .refRow   (refreshRow)
  );

  // live strobes gate the pins so release needs no clock edge
  assign dqDrive = rdValid & ~casN & ~oeN;

endmodule

// File: rtl/dram_front_chk.sv
module dram_front_chk (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic oeN,
  input logic dqDrive,
  input logic refreshPulse
);

  // R3
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN && !rasN) |=> !dqDrive);

  // R2
  drive_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqDrive |-> (!casN && !oeN));

  // R2
  drive_drops_on_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casN) |=> !dqDrive);

  // R6 R7
  refresh_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |=> !refreshPulse);

  // R6 R7
  refresh_after_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |-> ($past(rasN) != $past(rasN, 2)));

endmodule

bind dram_front dram_front_chk chkInst (
  .clk          (clk),
  .rstN         (rstN),
  .rasN         (rasN),
  .casN         (casN),
  .weN          (weN),
  .oeN          (oeN),
  .dqDrive      (dqDrive),
  .refreshPulse (refreshPulse)
);

// File: tb/tb_dram_front.sv
module tb_dram_front;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0] addr = '0;
  logic [3:0] dqIn = '0;
  logic [3:0] dqOut;
  logic       dqDrive, refreshPulse;
  logic [8:0] refreshRow;

  int nChk = 0, nFail = 0;
  int expQ[$];
  int cbrCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_front dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqDrive(dqDrive),
    .refreshPulse(refreshPulse), .refreshRow(refreshRow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor for refresh results
  always @(negedge clk) begin
    if (rstN && refreshPulse) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6", "unexpected refresh pulse row", int'(refreshRow), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        chk(int'(refreshRow) == e, "R7", "refresh row", int'(refreshRow), e);
      end
    end
  end

  task automatic openRow(input int r);
    addr = 9'(r); rasN = 1'b0; cyc(2);
  endtask

  task automatic closeRow();
    rasN = 1'b1; cyc(2);
  endtask

  task automatic pageWrite(input int c, input int d);
    addr = 9'(c); dqIn = 4'(d); weN = 1'b0; cyc(1);
    casN = 1'b0; oeN = 1'b0; cyc(2);
    chk(dqDrive == 1'b0, "R3", "early write drive", int'(dqDrive), 0);
    casN = 1'b1; weN = 1'b1; oeN = 1'b1; cyc(1);
  endtask

  task automatic pageRead(input int c, input int exp, input string req);
    addr = 9'(c); oeN = 1'b0; casN = 1'b0; cyc(2);
    chk(dqDrive == 1'b1, req, "read drive", int'(dqDrive), 1);
    chk(int'(dqOut) == exp, req, "read data", int'(dqOut), exp);
    casN = 1'b1; cyc(1);
    chk(dqDrive == 1'b0, "R2", "drive after cas rise", int'(dqDrive), 0);
    oeN = 1'b1;
  endtask

  task automatic rasOnly(input int r, input bit weLow);
    expQ.push_back(r);
    addr = 9'(r); dqIn = 4'hF; weN = ~weLow; oeN = ~weLow;
    rasN = 1'b0; cyc(3);
    rasN = 1'b1; cyc(2);
    weN = 1'b1; oeN = 1'b1;
  endtask

  task automatic cbr(input int junkAddr);
    expQ.push_back(cbrCnt);
    cbrCnt = (cbrCnt + 1) % 512;
    addr = 9'(junkAddr); dqIn = 4'h0; weN = 1'b0;
    casN = 1'b0; cyc(1);
    rasN = 1'b0; cyc(3);
    rasN = 1'b1; cyc(1);
    casN = 1'b1; weN = 1'b1; cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk(dqDrive == 1'b0, "R10", "drive in reset", int'(dqDrive), 0);
    chk(refreshPulse == 1'b0, "R10", "pulse in reset", int'(refreshPulse), 0);
    rstN = 1'b1; cyc(2);
    chk(dqDrive == 1'b0, "R10", "drive after reset", int'(dqDrive), 0);

    // R1 R3 R4: page writes and reads
    openRow(5);
    pageWrite(3, 4'hA);
    pageWrite(4, 4'h5);
    pageRead(3, 4'hA, "R4");
    pageRead(4, 4'h5, "R4");
    closeRow();
    openRow(2); pageWrite(3, 4'hC); closeRow();
    openRow(5); pageRead(3, 4'hA, "R1"); closeRow();
    openRow(2); pageRead(3, 4'hC, "R1"); closeRow();
    openRow(13); pageRead(19, 4'hA, "R1"); closeRow();   // aliasing

    // R2: output-enable gating
    openRow(5);
    addr = 9'd3; oeN = 1'b1; casN = 1'b0; cyc(2);
    chk(dqDrive == 1'b0, "R2", "oe high no drive", int'(dqDrive), 0);
    oeN = 1'b0; cyc(1);
    chk(dqDrive == 1'b1, "R2", "oe low drive", int'(dqDrive), 1);
    chk(int'(dqOut) == 4'hA, "R2", "oe low data", int'(dqOut), 4'hA);
    oeN = 1'b1; cyc(1);
    chk(dqDrive == 1'b0, "R2", "oe rise release", int'(dqDrive), 0);
    oeN = 1'b0; cyc(1);
    chk(dqDrive == 1'b1, "R2", "oe fall again", int'(dqDrive), 1);
    casN = 1'b1; cyc(1);
    chk(dqDrive == 1'b0, "R2", "cas rise release", int'(dqDrive), 0);
    oeN = 1'b1;
    closeRow();

    // R5: read-modify-write
    openRow(5);
    addr = 9'd4; oeN = 1'b0; casN = 1'b0; cyc(2);
    chk(int'(dqOut) == 4'h5, "R5", "rmw read", int'(dqOut), 4'h5);
    dqIn = 4'h9; weN = 1'b0; cyc(2);
    chk(dqDrive == 1'b1, "R5", "rmw still driving", int'(dqDrive), 1);
    chk(int'(dqOut) == 4'h5, "R5", "rmw old data kept", int'(dqOut), 4'h5);
    casN = 1'b1; weN = 1'b1; oeN = 1'b1; cyc(1);
    pageRead(4, 4'h9, "R5");
    closeRow();

    // R6: addressed refresh, write strobe ignored
    rasOnly(9'h1A5, 1'b1);
    rasOnly(9'h0FF, 1'b0);
    openRow(5); pageRead(3, 4'hA, "R6"); closeRow();

    // R7: counter refresh ignores address and write strobe
    cbr(5); cbr(5); cbr(2);
    openRow(5); pageRead(3, 4'hA, "R7"); closeRow();
    openRow(2); pageRead(3, 4'hC, "R7"); closeRow();

    // R9: hidden refresh
    openRow(2);
    addr = 9'd3; oeN = 1'b0; casN = 1'b0; cyc(2);
    expQ.push_back(cbrCnt);
    cbrCnt = (cbrCnt + 1) % 512;
    rasN = 1'b1; addr = 9'd7; cyc(2);
    chk(dqDrive == 1'b1, "R9", "hidden drive after ras rise", int'(dqDrive), 1);
    rasN = 1'b0; cyc(3);
    chk(dqDrive == 1'b1, "R9", "hidden drive during refresh", int'(dqDrive), 1);
    chk(int'(dqOut) == 4'hC, "R9", "hidden data", int'(dqOut), 4'hC);
    rasN = 1'b1; cyc(1);
    casN = 1'b1; oeN = 1'b1; cyc(2);

    // R8: counter wrap
    while (cbrCnt != 511) cbr(1);
    cbr(1);
    chk(cbrCnt == 0, "R8", "bench counter wrapped", cbrCnt, 0);
    cbr(1);
    cyc(1);
    chk(int'(refreshRow) == 0, "R8", "row after wrap", int'(refreshRow), 0);

    cyc(4);
    chk(expQ.size() == 0, "R6", "pending refreshes", expQ.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule